// File: doc/BRIEF.md
# Prioritized Stall Cycle Accounting Unit

This block watches a processor back end one clock cycle at a time and sorts every stalled cycle into a single cause. The pipeline presents six stall requests each cycle: exception flush, branch flush, data-cache/floating-point micropipeline hold, execute-stage operand wait, register-stack spill/fill and empty instruction buffer. A fixed priority encoder picks one winner, so the counts for the five top-level causes always add up to the total stall count. The flush cause is further split into its exception and branch parts, and those two also add up exactly.

Four 32-bit counters, each with its own event select, enable bit and sticky overflow flag, count any one of the classified events. They can also count three overlapping sub-events (integer operand wait, floating-point operand wait, long-latency integer chain wait) and a free-running cycle event. Software reaches the counters through a small register port: a write strobe with an address and data, and a separate read address with combinational read data. While the exception handler is running, the stall and sub-event inputs are ignored.

Top module: `stall_acct_unit`

## Requirements
- R1: Event code 2 (total stall) counts every cycle in which `handler_active` is low and at least one bit of `stall_req` is set.
- R2: Each counted stall cycle goes to exactly one of five causes, with codes 3 flush, 6 micropipeline hold, 7 execute wait, 8 register-stack activity and 9 front-end starvation. The five cause counts add up to the total stall count.
- R3: `stall_req` bit 0 is exception flush, bit 1 branch flush, bit 2 micropipeline hold, bit 3 execute wait, bit 4 register-stack activity and bit 5 front-end starvation. When several bits are set, the lowest-numbered set bit wins the cycle.
- R4: Code 4 (exception flush) and code 5 (branch flush) never count in the same cycle. Together their counts equal the code 3 flush count.
- R5: Each of the four counters adds exactly one in every cycle where it is enabled and its selected event is active. A disabled counter, or a counter whose select is 0 or 13..63, holds its value.
- R6: When a counter increments from all ones, it wraps to zero and sets its overflow flag. The flag stays set until a control write loads it from data bit 16.
- R7: A write to a counter value register loads the data on the next edge. In that cycle the counter does not increment, even if its event is active.
- R8: While `handler_active` is high, no stall event (codes 2..9) and no sub-event (codes 10..12) counts.
- R9: Sub-event codes 10, 11 and 12 follow `sub_evt` bits 0, 1 and 2 separately from the priority encoder. They may count in the same cycle as each other and as any cause.
- R10: Addresses 0..3 are counter controls: select in bits 5:0, enable in bit 8, overflow in bit 16. Addresses 4..7 hold counter values. `rd_data` shows the register at `rd_addr` combinationally, and everything reads zero after reset.
- R11: Event code 1 counts every cycle, including cycles with `handler_active` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| handler_active | input | 1 | Exception handler running; masks stall and sub-events |
| stall_req | input | 6 | Per-cause stall requests, bit 0 highest priority |
| sub_evt | input | 3 | Non-prioritized sub-events |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data for `rd_addr` |

## Verification
Two functions can land in the same cycle. The first case is several stall causes at once, where the priority encoder has to choose a single winner. Random six-bit request vectors with about a one-in-three chance per bit provoke this often. A stored stimulus run is replayed under two counter selections, and the cause counts are checked both against a model in the bench and for exact sums against the total stall and flush counts. The second case is a software value write meeting a counted event on the same edge. A counter is held on the every-cycle event while its value is written, and the bench expects the written value with no added increment, followed by normal counting and wraparound.

// File: rtl/sacct_pkg.sv
package sacct_pkg;

  localparam int NUM_CAUSE = 6;
  localparam int NUM_SUB   = 3;

  typedef enum logic [5:0] {
    EV_NONE      = 6'd0,
    EV_CYCLES    = 6'd1,
    EV_STALL     = 6'd2,
    EV_FLUSH     = 6'd3,
    EV_FL_EXC    = 6'd4,
    EV_FL_BR     = 6'd5,
    EV_HOLD      = 6'd6,
    EV_EXE       = 6'd7,
    EV_RSE       = 6'd8,
    EV_FE        = 6'd9,
    EV_SUB_INT   = 6'd10,
    EV_SUB_FP    = 6'd11,
    EV_SUB_CHAIN = 6'd12
  } evt_code_e;

  // Lowest set bit wins: bit 0 is the most downstream condition.
  function automatic logic [NUM_CAUSE-1:0] pick_cause(input logic [NUM_CAUSE-1:0] req);
    return req & (~req + 1'b1);
  endfunction

  // Next counter value and wrap flag for a one-step increment.
  function automatic logic [32:0] step_count(input logic [31:0] cur, input int width);
    logic [32:0] r;
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    r[31:0] = (cur + 32'd1) & mask;
    r[32]   = ((cur & mask) == mask);
    return r;
  endfunction

endpackage

// File: rtl/sacct_classifier.sv
module sacct_classifier
  import sacct_pkg::*;
#(
  parameter int SEL_W = 6,
  localparam int SLOTS = 1 << SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 handler_active,
  input  logic [NUM_CAUSE-1:0] stall_req,
  input  logic [NUM_SUB-1:0]   sub_evt,
  output logic [SLOTS-1:0]     evt_vec
);

  logic [NUM_CAUSE-1:0] live_req;
  logic [NUM_CAUSE-1:0] grant;
  logic [NUM_SUB-1:0]   live_sub;
  logic                 stalled;

  assign live_req = handler_active ? '0 : stall_req;
  assign live_sub = handler_active ? '0 : sub_evt;
  assign grant    = pick_cause(live_req);
  assign stalled  = |live_req;

  always_comb begin
    evt_vec                    = '0;
    evt_vec[int'(EV_CYCLES)]   = 1'b1;
    evt_vec[int'(EV_STALL)]    = stalled;
    evt_vec[int'(EV_FLUSH)]    = grant[0] | grant[1];
    evt_vec[int'(EV_FL_EXC)]   = grant[0];
    evt_vec[int'(EV_FL_BR)]    = grant[1];
    evt_vec[int'(EV_HOLD)]     = grant[2];
    evt_vec[int'(EV_EXE)]      = grant[3];
    evt_vec[int'(EV_RSE)]      = grant[4];
    evt_vec[int'(EV_FE)]       = grant[5];
    evt_vec[int'(EV_SUB_INT)]  = live_sub[0];
    evt_vec[int'(EV_SUB_FP)]   = live_sub[1];
    evt_vec[int'(EV_SUB_CHAIN)] = live_sub[2];
  end

  // R2: a stalled cycle raises exactly one of the five causes
  p_one_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vec[int'(EV_STALL)] |->
      $countones({evt_vec[int'(EV_FLUSH)], evt_vec[int'(EV_HOLD)], evt_vec[int'(EV_EXE)],
                  evt_vec[int'(EV_RSE)], evt_vec[int'(EV_FE)]}) == 1);

  // R3: a branch flush always beats an execute wait
  p_flush_over_exe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req[1] && !handler_active) |-> !evt_vec[int'(EV_EXE)] && evt_vec[int'(EV_FLUSH)]);

  // R4: flush splits into disjoint exception and branch parts
  p_flush_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vec[int'(EV_FLUSH)] |-> $onehot({evt_vec[int'(EV_FL_EXC)], evt_vec[int'(EV_FL_BR)]}));

  // R8: handler cycles raise no stall or sub-event
  p_handler_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    handler_active |-> evt_vec[int'(EV_SUB_CHAIN):int'(EV_STALL)] == '0);

endmodule

// File: rtl/sacct_counter.sv
module sacct_counter
  import sacct_pkg::*;
#(
  parameter int CTR_W = 32,
  parameter int SEL_W = 6,
  localparam int SLOTS = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] evt_vec,
  input  logic             ctl_we,
  input  logic [SEL_W-1:0] ctl_sel,
  input  logic             ctl_en,
  input  logic             ctl_ovf,
  input  logic             val_we,
  input  logic [CTR_W-1:0] val_wdata,
  output logic [SEL_W-1:0] sel_q,
  output logic             en_q,
  output logic             ovf_q,
  output logic [CTR_W-1:0] cnt_q
);

  logic        hit;
  logic        wrap;
  logic [32:0] stepped;
  logic [CTR_W-1:0] cnt_inc;

  assign hit     = en_q && evt_vec[sel_q];
  assign stepped = step_count(32'(cnt_q), CTR_W);
  assign cnt_inc = stepped[CTR_W-1:0];
  assign wrap    = hit && !val_we && stepped[32];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= 1'b0;
      ovf_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (ctl_we) begin
        sel_q <= ctl_sel;
        en_q  <= ctl_en;
      end
      ovf_q <= ctl_we ? ctl_ovf : (ovf_q | wrap);
      if (val_we)   cnt_q <= val_wdata;
      else if (hit) cnt_q <= cnt_inc;
    end
  end

  // R5: without a write the counter moves by zero or one
  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(val_we) |-> (cnt_q == $past(cnt_q)) || (cnt_q == CTR_W'($past(cnt_q) + 1'b1)));

  // R7: a value write lands exactly, with no increment on top
  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(val_we) |-> cnt_q == $past(val_wdata));

  // R6: overflow flag is sticky until a control write
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ovf_q) && !$past(ctl_we)) |-> ovf_q);

  // R6: a wrap from all ones sets the flag
  p_ovf_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(&cnt_q) && !$past(val_we) && !$past(ctl_we) && cnt_q == '0) |-> ovf_q);

endmodule

// File: rtl/stall_acct_unit.sv
module stall_acct_unit
  import sacct_pkg::*;
#(
  parameter int NUM_CTRS = 4,
  parameter int CTR_W    = 32,
  parameter int SEL_W    = 6,
  parameter int DATA_W   = 32,
  parameter int EN_BIT   = 8,
  parameter int OVF_BIT  = 16,
  localparam int IDX_W   = $clog2(NUM_CTRS),
  localparam int ADDR_W  = IDX_W + 1,
  localparam int SLOTS   = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              handler_active,
  input  logic [5:0]        stall_req,
  input  logic [2:0]        sub_evt,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [SLOTS-1:0] evt_vec;
  logic [NUM_CTRS-1:0] ctl_we, val_we;
  logic [SEL_W-1:0] sel_q [NUM_CTRS];
  logic             en_q  [NUM_CTRS];
  logic             ovf_q [NUM_CTRS];
  logic [CTR_W-1:0] cnt_q [NUM_CTRS];

  sacct_classifier #(.SEL_W(SEL_W)) u_class (
    .clk            (clk),
    .rst_n          (rst_n),
    .handler_active (handler_active),
    .stall_req      (stall_req),
    .sub_evt        (sub_evt),
    .evt_vec        (evt_vec)
  );

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
    assign ctl_we[i] = reg_we && !reg_addr[ADDR_W-1] && (reg_addr[IDX_W-1:0] == IDX_W'(i));
    assign val_we[i] = reg_we &&  reg_addr[ADDR_W-1] && (reg_addr[IDX_W-1:0] == IDX_W'(i));

    sacct_counter #(.CTR_W(CTR_W), .SEL_W(SEL_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_vec   (evt_vec),
      .ctl_we    (ctl_we[i]),
      .ctl_sel   (reg_wdata[SEL_W-1:0]),
      .ctl_en    (reg_wdata[EN_BIT]),
      .ctl_ovf   (reg_wdata[OVF_BIT]),
      .val_we    (val_we[i]),
      .val_wdata (reg_wdata[CTR_W-1:0]),
      .sel_q     (sel_q[i]),
      .en_q      (en_q[i]),
      .ovf_q     (ovf_q[i]),
      .cnt_q     (cnt_q[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CTRS; i++) begin
      if (rd_addr[IDX_W-1:0] == IDX_W'(i)) begin
        if (rd_addr[ADDR_W-1]) begin
          rd_data = DATA_W'(cnt_q[i]);
        end else begin
          rd_data[SEL_W-1:0] = sel_q[i];
          rd_data[EN_BIT]    = en_q[i];
          rd_data[OVF_BIT]   = ovf_q[i];
        end
      end
    end
  end

  // R10: one write strobe reaches at most one register
  p_single_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_we, val_we}));

endmodule

// File: tb/stall_acct_unit_test.sv
module stall_acct_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        handler_active = 1'b0;
  logic [5:0]  stall_req = '0;
  logic [2:0]  sub_evt = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int n_total = 0;
  int n_fail  = 0;
  int codes [4];
  longint expv [4];
  logic [9:0] stim [300];
  logic [31:0] ha [4];
  logic [31:0] hb [4];

  always #10 clk = ~clk;

  stall_acct_unit uut (
    .clk(clk), .rst_n(rst_n), .handler_active(handler_active),
    .stall_req(stall_req), .sub_evt(sub_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  initial begin
    #(20 * 200000);
    $display("FAIL watchdog expired: got hang expected finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total + 1);
    $finish;
  end

  function automatic bit ev_hit(int code, logic [5:0] c, logic [2:0] s, logic h);
    int win;
    bit st;
    st = !h && (c != 6'd0);
    win = 0;
    if (!h) begin
      if (c[0]) win = 4;
      else if (c[1]) win = 5;
      else if (c[2]) win = 6;
      else if (c[3]) win = 7;
      else if (c[4]) win = 8;
      else if (c[5]) win = 9;
    end
    case (code)
      1: return 1'b1;
      2: return st;
      3: return (win == 4) || (win == 5);
      10: return !h && s[0];
      11: return !h && s[1];
      12: return !h && s[2];
      default: return (code >= 4 && code <= 9) && (win == code);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic feed(input logic [5:0] c, input logic [2:0] s, input logic h);
    stall_req = c; sub_evt = s; handler_active = h;
    for (int i = 0; i < 4; i++) if (ev_hit(codes[i], c, s, h)) expv[i]++;
    @(negedge clk);
    stall_req = '0; sub_evt = '0; handler_active = 1'b0;
  endtask

  task automatic setup(input int c0, input int c1, input int c2, input int c3);
    codes[0] = c0; codes[1] = c1; codes[2] = c2; codes[3] = c3;
    for (int i = 0; i < 4; i++) wr(3'(i), 32'd0);
    for (int i = 0; i < 4; i++) wr(3'(4 + i), 32'd0);
    for (int i = 0; i < 4; i++) begin
      wr(3'(i), 32'h100 | 32'(codes[i]));
      expv[i] = 0;
    end
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), v);
      check(v == 32'(expv[i]), req, v, expv[i]);
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    for (int k = 0; k < 300; k++) begin
      for (int b = 0; b < 9; b++) stim[k][b] = ($urandom % 100) < 35;
      stim[k][9] = ($urandom % 100) < 10;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state of every register
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check(v == 32'd0, "R10 reset", v, 0);
    end

    // R3 directed: branch flush with execute wait goes to flush
    setup(3, 7, 2, 9);
    feed(6'b001010, 3'b000, 1'b0);
    check_all("R3 flush over exe");
    // R3: hold beats exe, rse and fe
    feed(6'b111100, 3'b000, 1'b0);
    rd(3'd5, v); check(v == 32'd0, "R3 hold wins, exe idle", v, 0);
    feed(6'b100000, 3'b000, 1'b0);
    rd(3'd7, v); check(v == 32'd1, "R3 fe alone", v, 1);
    rd(3'd6, v); check(v == 32'd3, "R1 total stall", v, 3);

    // R8: handler masks all stall and sub events
    setup(2, 3, 10, 9);
    feed(6'b111111, 3'b111, 1'b1);
    feed(6'b111111, 3'b111, 1'b1);
    check_all("R8 handler masked");
    rd(3'd4, v); check(v == 32'd0, "R8 total stall during handler", v, 0);

    // R9: sub-events overlap each other and a flush
    setup(10, 11, 12, 7);
    feed(6'b000001, 3'b111, 1'b0);
    feed(6'b001000, 3'b010, 1'b0);
    rd(3'd4, v); check(v == 32'd1, "R9 int sub", v, 1);
    rd(3'd5, v); check(v == 32'd2, "R9 fp sub", v, 2);
    rd(3'd6, v); check(v == 32'd1, "R9 chain sub", v, 1);
    rd(3'd7, v); check(v == 32'd1, "R9 exe once", v, 1);

    // R5: disabled counter and unused select hold
    wr(3'd0, 32'h0000_0002);
    wr(3'd1, 32'h0000_013F);
    feed(6'b000100, 3'b000, 1'b0);
    rd(3'd4, v); check(v == 32'd1, "R5 disabled holds", v, 1);
    rd(3'd5, v); check(v == 32'd2, "R5 unused select holds", v, 2);

    // R6 / R7 / R11 on counter 0 with the cycle event
    wr(3'd0, 32'h0000_0101);
    wr(3'd4, 32'hFFFF_FFFE);
    rd(3'd4, v); check(v == 32'hFFFF_FFFE, "R7 write wins over event", v, 32'hFFFF_FFFE);
    @(negedge clk);
    rd(3'd4, v); check(v == 32'hFFFF_FFFF, "R11 cycle count", v, 32'hFFFF_FFFF);
    rd(3'd0, v); check(v[16] == 1'b0, "R6 no overflow yet", v[16], 0);
    @(negedge clk);
    rd(3'd4, v); check(v == 32'd0, "R6 wrap to zero", v, 0);
    rd(3'd0, v); check(v[16] == 1'b1, "R6 overflow set", v[16], 1);
    @(negedge clk);
    rd(3'd0, v); check(v[16] == 1'b1, "R6 overflow sticky", v[16], 1);
    wr(3'd0, 32'h0000_0101);
    rd(3'd0, v); check(v == 32'h0000_0101, "R6 overflow cleared", v, 32'h101);
    rd(3'd4, v); check(v == 32'd2, "R11 counts through control write", v, 2);
    stall_req = 6'h3F; handler_active = 1'b1;
    repeat (3) @(negedge clk);
    stall_req = '0; handler_active = 1'b0;
    rd(3'd4, v); check(v == 32'd5, "R11 counts handler cycles", v, 5);

    // R2/R4 random run A
    setup(2, 3, 6, 7);
    for (int k = 0; k < 300; k++) feed(stim[k][5:0], stim[k][8:6], stim[k][9]);
    check_all("R2 run A vs model");
    for (int i = 0; i < 4; i++) rd(3'(4 + i), ha[i]);

    // R2/R4 random run B, same stimulus
    setup(8, 9, 4, 5);
    for (int k = 0; k < 300; k++) feed(stim[k][5:0], stim[k][8:6], stim[k][9]);
    check_all("R4 run B vs model");
    for (int i = 0; i < 4; i++) rd(3'(4 + i), hb[i]);

    check(ha[1] + ha[2] + ha[3] + hb[0] + hb[1] == ha[0], "R2 causes sum to total",
          ha[1] + ha[2] + ha[3] + hb[0] + hb[1], ha[0]);
    check(hb[2] + hb[3] == ha[1], "R4 flush parts sum", hb[2] + hb[3], ha[1]);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule